// File: doc/BRIEF.md
# Serial Transmitter with Timed Break

This block turns bytes into asynchronous serial frames. Bytes enter through a single-cycle push port into a 16-deep staging queue. A three-stage rate generator (a prescaler, a divisor, and a fixed 13-step oversampling counter) produces oversample ticks and bit ticks. The shift engine starts a frame only on a bit tick. The frame shape is taken from configuration inputs when the frame starts: 7 or 8 data bits, parity that may be even, odd or absent, and one or two stop bits.

Software can ask the block to hold the line low for a programmed number of oversample periods. The break begins at the next frame boundary and ends on an oversample tick, at which point a done pulse is raised. The block reports queue events (level falling to the low-water mark, queue emptied) and frame-end events (shift register drained, queue found empty). A rate change is held in a shadow until the engine is idle, and a busy output is high while it waits. An internal loopback routes the serial output to the receive-side line.

Top module: `uart_brk_tx`

## Requirements
- R1: One bit lasts (prediv_m1+1)*(divisor_m1+1)*13 clock cycles. The rate counters restart from zero whenever a new rate is applied. After reset the rate fields are 0, giving 13 cycles per bit.
- R2: A frame is a 0 start bit, then the data bits least significant first (8 when char_8bit=1, otherwise 7, with data bit 7 ignored), then an optional parity bit, then one stop bit of 1 (two when stop_2bit=1). The parity bit is present when parity_on=1. It equals the XOR of the sent data bits, inverted when parity_odd=1. Format inputs are sampled when a frame starts.
- R3: The queue holds 16 bytes and fifo_level reports the count. fifo_full is 1 exactly when the count is 16. A push while full is dropped.
- R4: A frame starts only on a bit tick, and only when tx_enable=1 and the queue is not empty. Frames follow one another with no idle bits in between. Clearing tx_enable lets the current frame finish but prevents the next one from starting.
- R5: evt_fifo_empty pulses for one cycle when the count becomes 0. evt_almost_empty pulses when the count falls from above 4 to 4 or below.
- R6: At the end of every frame, evt_data_empty pulses. evt_underrun pulses in the same cycle if tx_enable=1 and the queue is empty at that moment.
- R7: A brk_start pulse requests a break, which waits for the current frame to end. The line is driven low from a bit tick for max(brk_len,1) oversample periods. It is released on an oversample tick, and evt_brk_done pulses with the release.
- R8: div_load stores new rate fields and raises div_busy. The fields are applied in the first cycle the engine is idle, and div_busy then drops. A pending change makes the engine go idle at the next frame boundary.
- R9: When loopback=1, txd is held at 1 and rx_line follows the internal serial line. When loopback=0, rx_line equals rx_in.
- R10: After a synchronous reset the line is 1, the queue is empty, no event is active and div_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push one byte into the queue |
| push_data | input | 8 | Byte to push |
| tx_enable | input | 1 | Allow new frames to start |
| char_8bit | input | 1 | 1: 8 data bits, 0: 7 data bits |
| stop_2bit | input | 1 | 1: two stop bits |
| parity_on | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| loopback | input | 1 | Route the serial line internally |
| prediv_m1 | input | 4 | Prescaler minus one |
| divisor_m1 | input | 10 | Divisor minus one |
| div_load | input | 1 | Request a rate change |
| brk_start | input | 1 | Request a break |
| brk_len | input | 16 | Break length in oversample periods |
| rx_in | input | 1 | External receive line |
| txd | output | 1 | Serial output pin |
| rx_line | output | 1 | Line presented to the receiver |
| fifo_level | output | 5 | Bytes waiting in the queue |
| fifo_full | output | 1 | Queue holds 16 bytes |
| div_busy | output | 1 | Rate change pending |
| evt_data_empty | output | 1 | Frame finished |
| evt_almost_empty | output | 1 | Count fell to the low-water mark |
| evt_fifo_empty | output | 1 | Count became zero |
| evt_underrun | output | 1 | Frame ended with an empty queue while enabled |
| evt_brk_done | output | 1 | Break released |

## Verification
The hardest situations to reach are those where two requests meet at the same frame boundary: a rate change or a break arriving while a frame is on the wire, with more bytes still queued behind it. The stimulus pushes several bytes and then, a few cycles into the first frame, issues div_load or brk_start. This forces the engine to choose between chaining the next frame, entering the break and going idle. The low-water and emptying events are produced by filling the queue to its limit with transmission disabled, pushing two extra bytes that must be dropped, and then enabling transmission so the queue drains through every level.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_BREAK = 2'd2
  } utx_state_e;

  // Bits after the start bit, LSB first; unused positions stay 1 (stop level)
  function automatic logic [FRAME_W-1:0] frame_bits(
    input logic [DATA_W-1:0] d,
    input logic              eight,
    input logic              pen,
    input logic              podd
  );
    logic [FRAME_W-1:0] f;
    logic               par;
    f = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || eight) f[i] = d[i];
    end
    par = (eight ? ^d : ^d[DATA_W-2:0]) ^ podd;
    if (pen) f[eight ? DATA_W : DATA_W-1] = par;
    return f;
  endfunction

  function automatic logic [3:0] frame_len(
    input logic eight,
    input logic pen,
    input logic two
  );
    return 4'(DATA_W - 1) + {3'b0, eight} + {3'b0, pen} + {3'b0, two} + 4'd1;
  endfunction
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int AE_LEVEL = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                wr_data,
  input  logic                         pop,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty,
  output logic                         evt_empty,
  output logic                         evt_almost
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl, nlvl;
  logic          wr_en, rd_en;

  always_comb begin
    wr_en = push && (lvl != LW'(DEPTH));
    rd_en = pop && (lvl != '0);
    nlvl  = lvl + LW'(wr_en) - LW'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp         <= '0;
      rp         <= '0;
      lvl        <= '0;
      evt_empty  <= 1'b0;
      evt_almost <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + AW'(1);
      if (rd_en) rp <= rp + AW'(1);
      lvl        <= nlvl;
      evt_empty  <= (lvl != '0) && (nlvl == '0);
      evt_almost <= (lvl > LW'(AE_LEVEL)) && (nlvl <= LW'(AE_LEVEL));
    end
  end

  assign rd_data = mem[rp];
  assign level   = lvl;
  assign full    = (lvl == LW'(DEPTH));
  assign empty   = (lvl == '0);
endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 10,
  parameter int OSR   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_m1,
  input  logic [DIV_W-1:0] div_m1,
  output logic             os_tick,
  output logic             bit_tick
);
  localparam int OW = $clog2(OSR);

  logic [PRE_W-1:0] pcnt;
  logic [DIV_W-1:0] dcnt;
  logic [OW-1:0]    ocnt;
  logic             pre_tick;

  always_comb begin
    pre_tick = (pcnt == pre_m1);
    os_tick  = pre_tick && (dcnt == div_m1);
    bit_tick = os_tick && (ocnt == OW'(OSR - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
      dcnt <= '0;
      ocnt <= '0;
    end else begin
      pcnt <= pre_tick ? '0 : pcnt + PRE_W'(1);
      if (pre_tick) dcnt <= (dcnt == div_m1) ? '0 : dcnt + DIV_W'(1);
      if (os_tick)  ocnt <= bit_tick ? '0 : ocnt + OW'(1);
    end
  end
endmodule

// File: rtl/utx_engine.sv
module utx_engine
  import utx_pkg::*;
#(
  parameter int BRK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              os_tick,
  input  logic              hold,
  input  logic              div_pend,
  input  logic              tx_en,
  input  logic              eight,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              brk_start,
  input  logic [BRK_W-1:0]  brk_len,
  output logic              pop,
  output logic              line,
  output logic              idle,
  output logic              evt_data_empty,
  output logic              evt_underrun,
  output logic              evt_brk_done
);
  utx_state_e         st;
  logic [FRAME_W-1:0] sr;
  logic [3:0]         rem;
  logic [BRK_W-1:0]   bcnt;
  logic               brk_req;
  logic               tick, fend, decide, enter_brk, start;

  always_comb begin
    tick      = bit_tick && !hold;
    fend      = tick && (st == ST_SHIFT) && (rem == '0);
    decide    = tick && ((st == ST_IDLE) || fend);
    enter_brk = decide && !div_pend && brk_req;
    start     = decide && !div_pend && !brk_req && tx_en && !fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      line           <= 1'b1;
      sr             <= '1;
      rem            <= '0;
      bcnt           <= '0;
      brk_req        <= 1'b0;
      evt_data_empty <= 1'b0;
      evt_underrun   <= 1'b0;
      evt_brk_done   <= 1'b0;
    end else begin
      evt_data_empty <= fend;
      evt_underrun   <= fend && tx_en && fifo_empty;
      evt_brk_done   <= 1'b0;
      brk_req        <= (brk_req && !enter_brk) || brk_start;
      if (decide) begin
        if (enter_brk) begin
          st   <= ST_BREAK;
          line <= 1'b0;
          bcnt <= brk_len;
        end else if (start) begin
          st   <= ST_SHIFT;
          line <= 1'b0;
          sr   <= frame_bits(fifo_data, eight, par_en, par_odd);
          rem  <= frame_len(eight, par_en, two_stop);
        end else begin
          st   <= ST_IDLE;
          line <= 1'b1;
        end
      end else if (st == ST_SHIFT && tick) begin
        line <= sr[0];
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        rem  <= rem - 4'd1;
      end else if (st == ST_BREAK && os_tick) begin
        if (bcnt <= BRK_W'(1)) begin
          line         <= 1'b1;
          st           <= ST_IDLE;
          evt_brk_done <= 1'b1;
        end else begin
          bcnt <= bcnt - BRK_W'(1);
        end
      end
    end
  end

  assign pop  = start;
  assign idle = (st == ST_IDLE);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int FIFO_DEPTH   = 16,
  parameter int AE_LEVEL     = 4,
  parameter int PRE_W        = 4,
  parameter int DIV_W        = 10,
  parameter int OSR          = 13,
  parameter int BRK_W        = 16,
  parameter int RST_PRE_M1   = 0,
  parameter int RST_DIV_M1   = 0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              push_valid,
  input  logic [7:0]                        push_data,
  input  logic                              tx_enable,
  input  logic                              char_8bit,
  input  logic                              stop_2bit,
  input  logic                              parity_on,
  input  logic                              parity_odd,
  input  logic                              loopback,
  input  logic [PRE_W-1:0]                  prediv_m1,
  input  logic [DIV_W-1:0]                  divisor_m1,
  input  logic                              div_load,
  input  logic                              brk_start,
  input  logic [BRK_W-1:0]                  brk_len,
  input  logic                              rx_in,
  output logic                              txd,
  output logic                              rx_line,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
  output logic                              fifo_full,
  output logic                              div_busy,
  output logic                              evt_data_empty,
  output logic                              evt_almost_empty,
  output logic                              evt_fifo_empty,
  output logic                              evt_underrun,
  output logic                              evt_brk_done
);
  import utx_pkg::*;

  logic [PRE_W-1:0]  act_pre, sh_pre;
  logic [DIV_W-1:0]  act_div, sh_div;
  logic              pend, apply;
  logic              os_tick, bit_tick;
  logic              eng_idle, pop, line, f_empty;
  logic [DATA_W-1:0] f_data;

  assign apply = pend && eng_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre <= PRE_W'(RST_PRE_M1);
      act_div <= DIV_W'(RST_DIV_M1);
      sh_pre  <= PRE_W'(RST_PRE_M1);
      sh_div  <= DIV_W'(RST_DIV_M1);
      pend    <= 1'b0;
    end else begin
      if (apply) begin
        act_pre <= sh_pre;
        act_div <= sh_div;
      end
      if (div_load) begin
        sh_pre <= prediv_m1;
        sh_div <= divisor_m1;
        pend   <= 1'b1;
      end else if (apply) begin
        pend   <= 1'b0;
      end
    end
  end

  utx_baud #(.PRE_W(PRE_W), .DIV_W(DIV_W), .OSR(OSR)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .restart  (apply),
    .pre_m1   (act_pre),
    .div_m1   (act_div),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );

  utx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH), .AE_LEVEL(AE_LEVEL)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (push_valid),
    .wr_data    (push_data),
    .pop        (pop),
    .rd_data    (f_data),
    .level      (fifo_level),
    .full       (fifo_full),
    .empty      (f_empty),
    .evt_empty  (evt_fifo_empty),
    .evt_almost (evt_almost_empty)
  );

  utx_engine #(.BRK_W(BRK_W)) u_eng (
    .clk            (clk),
    .rst            (rst),
    .bit_tick       (bit_tick),
    .os_tick        (os_tick),
    .hold           (apply),
    .div_pend       (pend),
    .tx_en          (tx_enable),
    .eight          (char_8bit),
    .two_stop       (stop_2bit),
    .par_en         (parity_on),
    .par_odd        (parity_odd),
    .fifo_empty     (f_empty),
    .fifo_data      (f_data),
    .brk_start      (brk_start),
    .brk_len        (brk_len),
    .pop            (pop),
    .line           (line),
    .idle           (eng_idle),
    .evt_data_empty (evt_data_empty),
    .evt_underrun   (evt_underrun),
    .evt_brk_done   (evt_brk_done)
  );

  assign div_busy = pend;
  assign txd      = loopback ? 1'b1 : line;
  assign rx_line  = loopback ? line : rx_in;
endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [LW-1:0] fifo_level,
  input logic          txd,
  input logic          rx_line,
  input logic          loopback,
  input logic          evt_fifo_empty,
  input logic          evt_data_empty,
  input logic          evt_underrun,
  input logic          evt_brk_done
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_level) <= DEPTH);

  assert_level_step_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(fifo_level) <= int'($past(fifo_level)) + 1) &&
             (int'(fifo_level) + 1 >= int'($past(fifo_level))));

  assert_empty_evt_R5: assert property (@(posedge clk) disable iff (rst)
    evt_fifo_empty |-> (fifo_level == '0));

  assert_underrun_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
    evt_underrun |-> evt_data_empty);

  assert_brk_release_R7: assert property (@(posedge clk) disable iff (rst)
    evt_brk_done |-> (loopback ? rx_line : txd));
endmodule

bind uart_brk_tx utx_checker #(.DEPTH(FIFO_DEPTH), .LW($clog2(FIFO_DEPTH+1))) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fifo_level     (fifo_level),
  .txd            (txd),
  .rx_line        (rx_line),
  .loopback       (loopback),
  .evt_fifo_empty (evt_fifo_empty),
  .evt_data_empty (evt_data_empty),
  .evt_underrun   (evt_underrun),
  .evt_brk_done   (evt_brk_done)
);

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [7:0]  push_data = '0;
  logic        tx_enable = 1'b0, char_8bit = 1'b1, stop_2bit = 1'b0;
  logic        parity_on = 1'b0, parity_odd = 1'b0, loopback = 1'b0;
  logic [3:0]  prediv_m1 = '0;
  logic [9:0]  divisor_m1 = '0;
  logic        div_load = 1'b0, brk_start = 1'b0;
  logic [15:0] brk_len = '0;
  logic        rx_in = 1'b1;
  logic        txd, rx_line, fifo_full, div_busy;
  logic [4:0]  fifo_level;
  logic        evt_data_empty, evt_almost_empty, evt_fifo_empty, evt_underrun, evt_brk_done;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  uart_brk_tx u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .tx_enable(tx_enable), .char_8bit(char_8bit), .stop_2bit(stop_2bit),
    .parity_on(parity_on), .parity_odd(parity_odd), .loopback(loopback),
    .prediv_m1(prediv_m1), .divisor_m1(divisor_m1), .div_load(div_load),
    .brk_start(brk_start), .brk_len(brk_len), .rx_in(rx_in),
    .txd(txd), .rx_line(rx_line), .fifo_level(fifo_level), .fifo_full(fifo_full),
    .div_busy(div_busy), .evt_data_empty(evt_data_empty),
    .evt_almost_empty(evt_almost_empty), .evt_fifo_empty(evt_fifo_empty),
    .evt_underrun(evt_underrun), .evt_brk_done(evt_brk_done)
  );

  // Behavioural reference model
  logic [7:0] mq[$];
  int         mbits[$];
  int m_pc, m_dc, m_oc, m_pre, m_div, m_shpre, m_shdiv, m_bcnt, m_state;
  bit m_pend, m_breq, m_line, m_live = 0;
  bit e_de, e_ur, e_bd, e_fe, e_ae;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mbits.delete();
      m_pc = 0; m_dc = 0; m_oc = 0; m_pre = 0; m_div = 0; m_shpre = 0; m_shdiv = 0;
      m_bcnt = 0; m_state = 0; m_pend = 0; m_breq = 0; m_line = 1;
      e_de = 0; e_ur = 0; e_bd = 0; e_fe = 0; e_ae = 0;
      m_live = 1;
    end else begin
      bit pre_t, os_t, bit_t, apply, tk, fend, dec, popd, ent;
      int old_n;
      pre_t = (m_pc == m_pre);
      os_t  = pre_t && (m_dc == m_div);
      bit_t = os_t && (m_oc == 12);
      apply = m_pend && (m_state == 0);
      tk    = bit_t && !apply;
      fend  = tk && (m_state == 1) && (mbits.size() == 0);
      dec   = tk && ((m_state == 0) || fend);
      old_n = mq.size();
      e_de = fend;
      e_ur = fend && tx_enable && (old_n == 0);
      e_bd = 0; popd = 0; ent = 0;
      if (dec) begin
        if (m_pend) begin m_state = 0; m_line = 1; end
        else if (m_breq) begin m_state = 2; m_line = 0; m_bcnt = int'(brk_len); ent = 1; end
        else if (tx_enable && old_n > 0) begin
          int nb, p;
          nb = char_8bit ? 8 : 7;
          p = parity_odd ? 1 : 0;
          for (int i = 0; i < nb; i++) begin
            mbits.push_back(int'(mq[0][i]));
            p = p ^ int'(mq[0][i]);
          end
          if (parity_on) mbits.push_back(p);
          mbits.push_back(1);
          if (stop_2bit) mbits.push_back(1);
          popd = 1; m_state = 1; m_line = 0;
        end else begin m_state = 0; m_line = 1; end
      end else if (m_state == 1 && tk) begin
        m_line = mbits.pop_front() != 0;
      end else if (m_state == 2 && os_t) begin
        if (m_bcnt <= 1) begin m_line = 1; m_state = 0; e_bd = 1; end
        else m_bcnt = m_bcnt - 1;
      end
      m_breq = (m_breq && !ent) || brk_start;
      if (popd) void'(mq.pop_front());
      if (push_valid && old_n < 16) mq.push_back(push_data);
      e_fe = (old_n != 0) && (mq.size() == 0);
      e_ae = (old_n > 4) && (mq.size() <= 4);
      if (apply) begin
        m_pre = m_shpre; m_div = m_shdiv; m_pend = 0;
        m_pc = 0; m_dc = 0; m_oc = 0;
      end else begin
        if (pre_t) m_dc = (m_dc == m_div) ? 0 : m_dc + 1;
        if (os_t) m_oc = bit_t ? 0 : m_oc + 1;
        m_pc = pre_t ? 0 : m_pc + 1;
      end
      if (div_load) begin
        m_shpre = int'(prediv_m1); m_shdiv = int'(divisor_m1); m_pend = 1;
      end
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_live) begin
      chk("R1 R2 R4", "txd", int'(txd), loopback ? 1 : int'(m_line));
      chk("R9", "rx_line", int'(rx_line), loopback ? int'(m_line) : int'(rx_in));
      chk("R3", "fifo_level", int'(fifo_level), mq.size());
      chk("R3", "fifo_full", int'(fifo_full), int'(mq.size() == 16));
      chk("R8", "div_busy", int'(div_busy), int'(m_pend));
      chk("R6", "evt_data_empty", int'(evt_data_empty), int'(e_de));
      chk("R6", "evt_underrun", int'(evt_underrun), int'(e_ur));
      chk("R7", "evt_brk_done", int'(evt_brk_done), int'(e_bd));
      chk("R5", "evt_fifo_empty", int'(evt_fifo_empty), int'(e_fe));
      chk("R5", "evt_almost_empty", int'(evt_almost_empty), int'(e_ae));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d);
    push_valid = 1'b1; push_data = d;
    cyc(1);
    push_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    // R10: reset state
    chk("R10", "reset txd", int'(txd), 1);
    chk("R10", "reset level", int'(fifo_level), 0);
    chk("R10", "reset busy", int'(div_busy), 0);
    chk("R10", "reset events", int'({evt_data_empty, evt_almost_empty, evt_fifo_empty,
                                      evt_underrun, evt_brk_done}), 0);
    rst = 1'b0;
    cyc(2);
    // R2/R4: 8N1 back-to-back frames
    tx_enable = 1'b1;
    push(8'h55); push(8'hA3); push(8'h0F);
    cyc(500);
    // R2: 7 data bits, even parity, two stop bits
    char_8bit = 1'b0; parity_on = 1'b1; stop_2bit = 1'b1;
    push(8'hC5); push(8'h3C);
    cyc(400);
    // R2: 8 data bits, odd parity
    char_8bit = 1'b1; parity_odd = 1'b1; stop_2bit = 1'b0;
    push(8'h81); push(8'h7E);
    cyc(400);
    // R3/R5: fill with transmission disabled, two pushes dropped
    parity_on = 1'b0; parity_odd = 1'b0;
    tx_enable = 1'b0;
    for (int i = 0; i < 18; i++) push(8'(i * 7 + 3));
    chk("R3", "full level", int'(fifo_level), 16);
    chk("R3", "full flag", int'(fifo_full), 1);
    tx_enable = 1'b1;
    cyc(2400);
    // R7: break requested during a frame, then a zero-length break
    brk_len = 16'd30;
    push(8'h96);
    cyc(20);
    brk_start = 1'b1; cyc(1); brk_start = 1'b0;
    cyc(700);
    brk_len = 16'd0;
    brk_start = 1'b1; cyc(1); brk_start = 1'b0;
    cyc(100);
    // R9: loopback, external input ignored
    loopback = 1'b1; rx_in = 1'b0;
    push(8'h5A);
    cyc(200);
    loopback = 1'b0; rx_in = 1'b1;
    cyc(20);
    // R4: disabling mid-frame lets the frame finish, next one waits
    push(8'h11); push(8'h22);
    cyc(30);
    tx_enable = 1'b0;
    cyc(300);
    chk("R4", "held byte", int'(fifo_level), 1);
    tx_enable = 1'b1;
    cyc(200);
    // R8: rate change requested mid-frame with bytes queued
    push(8'hE1); push(8'h1E);
    cyc(25);
    prediv_m1 = 4'd1; divisor_m1 = 10'd2;
    div_load = 1'b1; cyc(1); div_load = 1'b0;
    chk("R8", "busy while framing", int'(div_busy), 1);
    cyc(2000);
    // R1: measure 9 low bits (start + 8 zero data) at 2*3*13 cycles per bit
    push(8'h00);
    begin
      int n;
      n = 0;
      while (txd !== 1'b0) @(negedge clk);
      while (txd === 1'b0) begin n++; @(negedge clk); end
      chk("R1", "low run length", n, 9 * 78);
    end
    cyc(200);
    // R8: change back while idle
    prediv_m1 = 4'd0; divisor_m1 = 10'd0;
    div_load = 1'b1; cyc(1); div_load = 1'b0;
    cyc(5);
    chk("R8", "applied when idle", int'(div_busy), 0);
    push(8'hF0);
    cyc(300);
    finish_run();
  end
endmodule